// File: doc/BRIEF.md
# Memory-Mapped IDE Register Bridge

This block places an IDE task-file register set behind a 4 KiB memory-mapped window on a simple request bus. Each request carries an address, an access size (byte, halfword or word), a write flag and write data. The bridge takes a register index from the address, where registers sit 16 bytes apart. It then routes the access to one of three places: the seven task-file registers, the device-control/alternate-status pair (reachable at two aliased indices), or the data port.

The bus is big-endian and the device is little-endian, so halfword and word traffic through the data port is byte-reversed in both directions. Byte traffic to the task file passes through unchanged. Anything the bridge does not map reads back as all ones and is dropped on write. Read data is registered and comes back one cycle after the request with a valid strobe. A small register stub stands in for the drive. It provides a data latch, a sector byte counter and two interrupt lines, one for the drive and one for the DMA channel.

Top module: `mmio_ide_bridge`

## Requirements
- R1: The register index is address bits [11:4]. Address bits above bit 11 and bits [3:0] have no effect on decode.
- R2: Byte accesses at indices 1..7 reach the task file. Indices 2..6 read back the last byte written there. A read at index 1 returns the error value 0x00. A read at index 7 returns the status byte.
- R3: Byte writes at index 8 or index 22 load device control, where bit 1 set masks the drive interrupt output. Byte reads at index 8 or 22 return the status byte and leave a pending drive interrupt set.
- R4: A byte read at any index other than 1..8 and 22 returns 0x000000FF. A byte write there changes no register, including the data latch at index 0.
- R5: Halfword and word accesses reach only index 0. Elsewhere a halfword read returns 0x0000FFFF and a word read returns 0xFFFFFFFF. The reserved size code 3 also reads 0xFFFFFFFF. Writes of any of these change nothing.
- R6: Size codes are 0 byte, 1 halfword, 2 word. A data-port halfword swaps its two bytes, in both directions, against the low 16 bits of the device latch. A data-port word reverses all four bytes. A halfword write leaves the latch's upper 16 bits unchanged, and a halfword read returns zero in bits [31:16].
- R7: A byte write at index 7 (command) sets the drive interrupt pending. drive_irq equals pending AND NOT the device-control mask bit. A byte read at index 7 clears the pending flag.
- R8: A command write clears the data-port byte counter and dma_irq. Every data-port access adds its size in bytes (2 or 4) to the counter. When the running total reaches SECTOR_BYTES (512), dma_irq is set.
- R9: A read request gives rsp_valid high for exactly one cycle, in the cycle after the request, with the read data. Writes and idle cycles give rsp_valid low.
- R10: After reset, task-file registers and device control are zero, status reads 0x50, and both interrupts and rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | ADDR_W | Byte address; bits [11:4] select the register |
| req_wdata | input | DATA_W | Write data, bus byte order |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data, bus byte order |
| drive_irq | output | 1 | Drive interrupt |
| dma_irq | output | 1 | DMA channel interrupt |

## Verification
Decode is tried with aliased addresses that set high and low address bits, with both control indices, and with sizes aimed at the wrong index. This separates a full-index decode from a partial one and separates the size check from the index check. The swap is tried by writing at one size and reading back at the other. A missing swap in either direction, or a halfword reaching the wrong lanes, then gives a distinct value instead of cancelling out. The interrupt tests separate a status read from an alternate-status read and apply the mask after the interrupt is already pending. The sector test mixes halfword and word accesses and stops one access short of the boundary, so counting by access rather than by bytes is caught.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;
  localparam int STRIDE_LOG2 = 4;
  localparam int WINDOW_LOG2 = 12;
  localparam int IDX_W       = WINDOW_LOG2 - STRIDE_LOG2;

  localparam int DATA_IDX   = 0;
  localparam int CTRL_IDX_A = 8;
  localparam int CTRL_IDX_B = 22;
  localparam logic [2:0] TF_ERR_SEL = 3'd1;
  localparam logic [2:0] TF_CMD_SEL = 3'd7;

  localparam logic [7:0] STATUS_IDLE = 8'h50;
  localparam logic [7:0] ERROR_NONE  = 8'h00;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_TASK = 2'd1,
    TGT_CTRL = 2'd2,
    TGT_DATA = 2'd3
  } target_e;
endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
  import ide_bridge_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output target_e           target,
  output logic [2:0]        tf_sel
);
  logic [IDX_W-1:0] idx;
  logic             unused_addr_bits;

  assign idx = addr[WINDOW_LOG2-1:STRIDE_LOG2];
  assign unused_addr_bits = ^{addr[ADDR_W-1:WINDOW_LOG2], addr[STRIDE_LOG2-1:0]};
  assign tf_sel = idx[2:0];

  always_comb begin
    target = TGT_NONE;
    if (size == SZ_BYTE) begin
      if (idx >= IDX_W'(1) && idx <= IDX_W'(7))
        target = TGT_TASK;
      else if (idx == IDX_W'(CTRL_IDX_A) || idx == IDX_W'(CTRL_IDX_B))
        target = TGT_CTRL;
    end else if (size == SZ_HALF || size == SZ_WORD) begin
      if (idx == IDX_W'(DATA_IDX))
        target = TGT_DATA;
    end
  end
endmodule

// File: rtl/ide_lane_swap.sv
module ide_lane_swap
  import ide_bridge_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] rev_all;
  logic [15:0]       rev_half;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_rev
      assign rev_all[l*8 +: 8] = din[(LANES-1-l)*8 +: 8];
    end
  endgenerate

  assign rev_half = {din[7:0], din[15:8]};

  always_comb begin
    case (size)
      SZ_BYTE: dout = {{(DATA_W-8){1'b0}}, din[7:0]};
      SZ_HALF: dout = {{(DATA_W-16){1'b0}}, rev_half};
      default: dout = rev_all;
    endcase
  end
endmodule

// File: rtl/ide_taskfile_stub.sv
module ide_taskfile_stub
  import ide_bridge_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int SECTOR_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tf_we,
  input  logic              tf_re,
  input  logic [2:0]        tf_sel,
  input  logic [7:0]        tf_wdata,
  input  logic              ctrl_we,
  input  logic              ctrl_re,
  input  logic              ctrl_nien,
  input  logic              data_we,
  input  logic              data_re,
  input  logic [1:0]        data_size,
  input  logic [DATA_W-1:0] data_wdata,
  output logic [7:0]        tf_rdata,
  output logic [7:0]        alt_status,
  output logic [DATA_W-1:0] data_rdata,
  output logic              drive_irq,
  output logic              dma_irq
);
  localparam int LANES = DATA_W / 8;
  localparam int CNT_W = $clog2(SECTOR_BYTES) + 2;

  logic [7:0]       tf_q [0:7];
  logic [7:0]       status_q;
  logic             nien_q;
  logic             irq_pend_q;
  logic             dma_pend_q;
  logic [CNT_W-1:0] xfer_cnt_q;
  logic [CNT_W-1:0] acc_bytes;
  logic [CNT_W-1:0] cnt_sum;
  logic [7:0]       data_lane_q [LANES];
  logic [LANES-1:0] lane_en;
  logic             cmd_wr;

  assign cmd_wr = tf_we && (tf_sel == TF_CMD_SEL);

  always_comb begin
    case (data_size)
      SZ_BYTE: acc_bytes = CNT_W'(1);
      SZ_HALF: acc_bytes = CNT_W'(2);
      default: acc_bytes = CNT_W'(LANES);
    endcase
  end
  assign cnt_sum = xfer_cnt_q + acc_bytes;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) tf_q[i] <= 8'h00;
      status_q   <= STATUS_IDLE;
      nien_q     <= 1'b0;
      irq_pend_q <= 1'b0;
    end else begin
      if (tf_we) tf_q[tf_sel] <= tf_wdata;
      if (ctrl_we) nien_q <= ctrl_nien;
      if (cmd_wr) begin
        status_q   <= STATUS_IDLE;
        irq_pend_q <= 1'b1;
      end else if (tf_re && tf_sel == TF_CMD_SEL) begin
        irq_pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_cnt_q <= '0;
      dma_pend_q <= 1'b0;
    end else if (cmd_wr) begin
      xfer_cnt_q <= '0;
      dma_pend_q <= 1'b0;
    end else if (data_we || data_re) begin
      if (cnt_sum >= CNT_W'(SECTOR_BYTES)) begin
        xfer_cnt_q <= cnt_sum - CNT_W'(SECTOR_BYTES);
        dma_pend_q <= 1'b1;
      end else begin
        xfer_cnt_q <= cnt_sum;
      end
    end
  end

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_en[l] = (CNT_W'(l) < acc_bytes);
      always_ff @(posedge clk) begin
        if (rst)
          data_lane_q[l] <= 8'h00;
        else if (data_we && lane_en[l])
          data_lane_q[l] <= data_wdata[l*8 +: 8];
      end
      assign data_rdata[l*8 +: 8] = data_lane_q[l];
    end
  endgenerate

  always_comb begin
    case (tf_sel)
      TF_ERR_SEL: tf_rdata = ERROR_NONE;
      TF_CMD_SEL: tf_rdata = status_q;
      3'd0:       tf_rdata = 8'hFF;
      default:    tf_rdata = tf_q[tf_sel];
    endcase
  end

  assign alt_status = status_q;
  assign drive_irq  = irq_pend_q && !nien_q;
  assign dma_irq    = dma_pend_q;

  // R10
  reset_irq_low_chk: assert property (@(posedge clk)
    rst |=> (!drive_irq && !dma_irq));

  // R3
  alt_keeps_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_re && irq_pend_q && !tf_we) |=> irq_pend_q);

  // R7
  status_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (tf_re && tf_sel == TF_CMD_SEL) |=> !irq_pend_q);

  // R8
  dma_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_irq) |-> $past(data_we || data_re));
endmodule

// File: rtl/mmio_ide_bridge.sv
module mmio_ide_bridge
  import ide_bridge_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int SECTOR_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              drive_irq,
  output logic              dma_irq
);
  target_e           tgt;
  logic [2:0]        tf_sel;
  logic              is_rd;
  logic              is_wr;
  logic [DATA_W-1:0] wdata_dev;
  logic [DATA_W-1:0] rdata_dev;
  logic [DATA_W-1:0] rdata_bus;
  logic [7:0]        tf_rdata;
  logic [7:0]        alt_status;
  logic [DATA_W-1:0] rd_next;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  assign is_rd = req_valid && !req_write;
  assign is_wr = req_valid && req_write;

  ide_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (req_addr),
    .size   (req_size),
    .target (tgt),
    .tf_sel (tf_sel)
  );

  ide_lane_swap #(.DATA_W(DATA_W)) u_swap_wr (
    .size (req_size),
    .din  (req_wdata),
    .dout (wdata_dev)
  );

  ide_lane_swap #(.DATA_W(DATA_W)) u_swap_rd (
    .size (req_size),
    .din  (rdata_dev),
    .dout (rdata_bus)
  );

  ide_taskfile_stub #(.DATA_W(DATA_W), .SECTOR_BYTES(SECTOR_BYTES)) u_stub (
    .clk        (clk),
    .rst        (rst),
    .tf_we      (is_wr && tgt == TGT_TASK),
    .tf_re      (is_rd && tgt == TGT_TASK),
    .tf_sel     (tf_sel),
    .tf_wdata   (req_wdata[7:0]),
    .ctrl_we    (is_wr && tgt == TGT_CTRL),
    .ctrl_re    (is_rd && tgt == TGT_CTRL),
    .ctrl_nien  (req_wdata[1]),
    .data_we    (is_wr && tgt == TGT_DATA),
    .data_re    (is_rd && tgt == TGT_DATA),
    .data_size  (req_size),
    .data_wdata (wdata_dev),
    .tf_rdata   (tf_rdata),
    .alt_status (alt_status),
    .data_rdata (rdata_dev),
    .drive_irq  (drive_irq),
    .dma_irq    (dma_irq)
  );

  always_comb begin
    case (tgt)
      TGT_TASK: rd_next = {{(DATA_W-8){1'b0}}, tf_rdata};
      TGT_CTRL: rd_next = {{(DATA_W-8){1'b0}}, alt_status};
      TGT_DATA: rd_next = rdata_bus;
      default: begin
        case (req_size)
          SZ_BYTE: rd_next = {{(DATA_W-8){1'b0}}, 8'hFF};
          SZ_HALF: rd_next = {{(DATA_W-16){1'b0}}, 16'hFFFF};
          default: rd_next = {DATA_W{1'b1}};
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= is_rd;
      if (is_rd) rsp_rdata_q <= rd_next;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  // R4
  unmapped_byte_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (is_rd && tgt == TGT_NONE && req_size == SZ_BYTE) |=> (rsp_rdata == DATA_W'(8'hFF)));

  // R9
  rd_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    is_rd |=> rsp_valid);

  // R9
  no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !is_rd |=> !rsp_valid);
endmodule

// File: tb/tb_mmio_ide_bridge.sv
module tb_mmio_ide_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        drive_irq;
  logic        dma_irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] got;
  logic        got_vld;

  always #2 clk = ~clk;

  mmio_ide_bridge dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .drive_irq(drive_irq), .dma_irq(dma_irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    got = rsp_rdata; got_vld = rsp_valid;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] exp, input string tag);
    acc(1'b0, sz, a, 32'h0);
    chk(got_vld && got == exp, tag, got, exp);
  endtask

  task automatic t_reset;
    chk(!drive_irq && !dma_irq && !rsp_valid, "R10 outputs low", {29'h0, drive_irq, dma_irq, rsp_valid}, 32'h0);
    rd_chk(2'd0, 32'h070, 32'h50, "R10 status");
    rd_chk(2'd0, 32'h030, 32'h00, "R10 lba lo zero");
    rd_chk(2'd2, 32'h000, 32'h0, "R10 data latch zero");
  endtask

  task automatic t_taskfile;
    for (int i = 2; i <= 6; i++) acc(1'b1, 2'd0, 32'(i) << 4, 32'hA0 + 32'(i));
    for (int i = 2; i <= 6; i++) rd_chk(2'd0, 32'(i) << 4, 32'hA0 + 32'(i), "R2 readback");
    acc(1'b1, 2'd0, 32'h010, 32'h33);
    rd_chk(2'd0, 32'h010, 32'h00, "R2 error reads zero");
    acc(1'b1, 2'd0, 32'hFFFF_1034, 32'h5A);
    rd_chk(2'd0, 32'h030, 32'h5A, "R1 aliased write");
    rd_chk(2'd0, 32'h0004_003F, 32'h5A, "R1 aliased read");
  endtask

  task automatic t_unmapped;
    rd_chk(2'd0, 32'h090, 32'hFF, "R4 byte idx9");
    rd_chk(2'd0, 32'hFF0, 32'hFF, "R4 byte idx255");
    acc(1'b1, 2'd0, 32'h000, 32'h77);
    rd_chk(2'd2, 32'h000, 32'h0, "R4 byte write idx0 ignored");
    acc(1'b1, 2'd0, 32'h090, 32'h11);
    rd_chk(2'd0, 32'h040, 32'hA4, "R4 byte write idx9 ignored");
    rd_chk(2'd1, 32'h030, 32'hFFFF, "R5 half wrong idx");
    rd_chk(2'd2, 32'h070, 32'hFFFF_FFFF, "R5 word wrong idx");
    rd_chk(2'd3, 32'h000, 32'hFFFF_FFFF, "R5 size3");
    acc(1'b1, 2'd2, 32'h030, 32'h1234_5678);
    acc(1'b1, 2'd3, 32'h000, 32'hDEAD_BEEF);
    rd_chk(2'd0, 32'h030, 32'h5A, "R5 word write idx3 ignored");
    rd_chk(2'd2, 32'h000, 32'h0, "R5 size3 write ignored");
  endtask

  task automatic t_swap;
    acc(1'b1, 2'd2, 32'h000, 32'h1122_3344);
    rd_chk(2'd2, 32'h000, 32'h1122_3344, "R6 word round trip");
    rd_chk(2'd1, 32'h000, 32'h0000_1122, "R6 half read of word");
    acc(1'b1, 2'd1, 32'h000, 32'hFFFF_AABB);
    rd_chk(2'd2, 32'h000, 32'hAABB_3344, "R6 half write into word");
  endtask

  task automatic t_irq;
    rd_chk(2'd0, 32'h070, 32'h50, "R7 status pre");
    chk(!drive_irq, "R7 idle", {31'h0, drive_irq}, 32'h0);
    acc(1'b1, 2'd0, 32'h080, 32'h02);
    acc(1'b1, 2'd0, 32'h070, 32'hC8);
    chk(!drive_irq, "R3 masked", {31'h0, drive_irq}, 32'h0);
    acc(1'b1, 2'd0, 32'h160, 32'h00);
    chk(drive_irq, "R3 unmask idx22", {31'h0, drive_irq}, 32'h1);
    rd_chk(2'd0, 32'h160, 32'h50, "R3 alt status idx22");
    rd_chk(2'd0, 32'h080, 32'h50, "R3 alt status idx8");
    chk(drive_irq, "R3 alt keeps irq", {31'h0, drive_irq}, 32'h1);
    rd_chk(2'd0, 32'h070, 32'h50, "R7 status read");
    chk(!drive_irq, "R7 status clears", {31'h0, drive_irq}, 32'h0);
  endtask

  task automatic t_sector;
    acc(1'b1, 2'd0, 32'h070, 32'h20);
    for (int i = 0; i < 127; i++) acc(1'b1, 2'd2, 32'h000, 32'(i));
    chk(!dma_irq, "R8 one short", {31'h0, dma_irq}, 32'h0);
    acc(1'b1, 2'd2, 32'h000, 32'h0);
    chk(dma_irq, "R8 words reach sector", {31'h0, dma_irq}, 32'h1);
    acc(1'b1, 2'd0, 32'h070, 32'h20);
    chk(!dma_irq, "R8 cmd clears", {31'h0, dma_irq}, 32'h0);
    for (int i = 0; i < 254; i++) acc(1'b0, 2'd1, 32'h000, 32'h0);
    chk(!dma_irq, "R8 halves short", {31'h0, dma_irq}, 32'h0);
    acc(1'b0, 2'd2, 32'h000, 32'h0);
    chk(dma_irq, "R8 mixed reach sector", {31'h0, dma_irq}, 32'h1);
  endtask

  task automatic t_resp;
    acc(1'b0, 2'd0, 32'h070, 32'h0);
    chk(got_vld, "R9 valid after read", {31'h0, got_vld}, 32'h1);
    @(posedge clk); #1;
    chk(!rsp_valid, "R9 single pulse", {31'h0, rsp_valid}, 32'h0);
    acc(1'b1, 2'd0, 32'h020, 32'h9);
    chk(!got_vld, "R9 no valid on write", {31'h0, got_vld}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    t_reset();
    t_taskfile();
    t_unmapped();
    t_swap();
    t_irq();
    t_sector();
    t_resp();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule